// File: doc/BRIEF.md
# Transmit Subaddress Descriptor Control Register

This block keeps the 16-bit control word for one transmit subaddress of a serial-bus remote terminal. Two parties share the word. The host reads and writes it through a simple register port. The terminal's message engine reports completed commands through a one-cycle completion strobe.

Each bit has its own write rule, and some rules depend on whether terminal execution is enabled. The device owns the status bits: an accessed flag, a buffer-select flag and a broadcast flag. The host owns the enable bits and a forced-busy bit. A host read clears the accessed flag. A software reset clears only the three device status bits.

When a qualifying completion occurs, the block raises one-cycle interrupt requests for an access event and for the buffer index reaching zero. Both requests go to the interrupt line and to the log request. The forced-busy bit is also driven straight out as the busy-response flag.

Top module: `tx_sa_ctrl_word`

## Requirements
- R1: Master reset (rst_n low) clears the word to 0x0000 and holds every interrupt output and busy_resp low.
- R2: Host writes to bits 15, 14, 12 and 3 take effect whatever the state of exec_en. Bit 13 always reads 0.
- R3: Host writes to bits 7:4 and 2:0 take effect only while exec_en is 0. While exec_en is 1, those bits do not change.
- R4: Host writes never change bits 11:8. Those bits change only on a completion, a host read or a software reset.
- R5: A completion strobe counts only if all of the following hold: exec_en is 1, cmd_tr is 1, and cmd_sa is in the range 1 to 30. A strobe that fails any of these leaves the word unchanged and raises no interrupt.
- R6: A counted completion sets bit 11, the accessed flag. If cmd_bcast is 1, it also sets bit 9, the broadcast flag.
- R7: A counted completion inverts bit 10, the buffer select, only while bit 12 (forced busy) is 0. busy_resp always equals bit 12.
- R8: host_rdata shows the current word. A cycle with host_rd set clears bit 11 at the next edge. If a counted completion falls in that same cycle, the set wins.
- R9: soft_rst clears bits 11:9 and leaves every other bit unchanged. In the same cycle it overrides a completion, so no status update and no interrupt result.
- R10: irq_access pulses for one cycle, in the cycle after a counted completion, when bit 14 and glb_acc_irq_en are both 1.
- R11: irq_idx_zero pulses for one cycle, in the cycle after a counted completion with idx_zero set, when bit 15 and glb_idx_irq_en are both 1.
- R12: irq_line and log_req are high in exactly the cycles where irq_access or irq_idx_zero is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset pulse, synchronous |
| exec_en | input | 1 | Terminal execution enabled |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Current control word |
| msg_done | input | 1 | Completion strobe for a command |
| cmd_tr | input | 1 | Command direction bit, 1 means transmit |
| cmd_sa | input | 5 | Command subaddress |
| cmd_bcast | input | 1 | Command was broadcast |
| idx_zero | input | 1 | Buffer index went from 1 to 0 in this command |
| glb_idx_irq_en | input | 1 | Global enable for the index-zero interrupt |
| glb_acc_irq_en | input | 1 | Global enable for the access interrupt |
| busy_resp | output | 1 | Respond busy; no data words and no buffer toggle |
| irq_idx_zero | output | 1 | Index-zero pending-interrupt pulse |
| irq_access | output | 1 | Access pending-interrupt pulse |
| irq_line | output | 1 | Message interrupt output |
| log_req | output | 1 | Interrupt log entry request |

## Verification
Two pairs of events can land on the same edge. A host read can clear the accessed flag while a completion sets it. A software reset can clear the status bits while a completion updates them.

The bench drives each pair in a single cycle: the read strobe together with a broadcast completion, and the soft reset together with a valid completion. It then checks the word after the edge. For the first pair, the accessed flag must be set, the buffer select inverted and the broadcast flag set. For the second pair, bits 11:9 must be clear and no interrupt pulse may appear.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
package tsa_pkg;
    localparam int WORD_W     = 16;
    localparam int B_IDX_IRQ  = 15;
    localparam int B_ACC_IRQ  = 14;
    localparam int B_SPARE    = 13;
    localparam int B_BUSY     = 12;
    localparam int B_ACCESSED = 11;
    localparam int B_BUFSEL   = 10;
    localparam int B_BCAST    = 9;

    // host bits writable at any time
    localparam logic [WORD_W-1:0] M_ANYTIME = (WORD_W'(1) << B_IDX_IRQ) | (WORD_W'(1) << B_ACC_IRQ)
                                             | (WORD_W'(1) << B_BUSY) | (WORD_W'(1) << 3);
    // host bits writable only while execution is stopped
    localparam logic [WORD_W-1:0] M_IDLE    = 16'h00F7;
    // device status bits cleared by software reset
    localparam logic [WORD_W-1:0] M_SOFT    = (WORD_W'(1) << B_ACCESSED) | (WORD_W'(1) << B_BUFSEL)
                                             | (WORD_W'(1) << B_BCAST);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              irq_idx;
        logic              irq_acc;
    } st_t;
endpackage

// File: rtl/tsa_cmd_qual.sv
`timescale 1ns/1ps
module tsa_cmd_qual #(
    parameter int SA_W  = 5,
    parameter int SA_LO = 1,
    parameter int SA_HI = 30
) (
    input  logic            msg_done,
    input  logic            exec_en,
    input  logic            cmd_tr,
    input  logic [SA_W-1:0] cmd_sa,
    output logic            hit
);
    localparam logic [SA_W-1:0] LO = SA_W'(SA_LO);
    localparam logic [SA_W-1:0] HI = SA_W'(SA_HI);

    always_comb begin
        hit = msg_done && exec_en && cmd_tr && (cmd_sa >= LO) && (cmd_sa <= HI);
    end
endmodule

// File: rtl/tsa_host_merge.sv
`timescale 1ns/1ps
module tsa_host_merge import tsa_pkg::*; (
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] wdata,
    input  logic              wr,
    input  logic              exec_en,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] wmask;

    always_comb begin
        wmask = '0;
        if (wr) begin
            wmask = exec_en ? M_ANYTIME : (M_ANYTIME | M_IDLE);
        end
        merged = (cur & ~wmask) | (wdata & wmask);
    end
endmodule

// File: rtl/tsa_irq_req.sv
`timescale 1ns/1ps
module tsa_irq_req (
    input  logic hit,
    input  logic idx_zero,
    input  logic en_idx_local,
    input  logic en_acc_local,
    input  logic en_idx_glb,
    input  logic en_acc_glb,
    output logic req_idx,
    output logic req_acc
);
    always_comb begin
        req_acc = hit && en_acc_local && en_acc_glb;
        req_idx = hit && idx_zero && en_idx_local && en_idx_glb;
    end
endmodule

// File: rtl/tx_sa_ctrl_word.sv
`timescale 1ns/1ps
module tx_sa_ctrl_word import tsa_pkg::*; #(
    parameter int SA_W  = 5,
    parameter int SA_LO = 1,
    parameter int SA_HI = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              exec_en,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              msg_done,
    input  logic              cmd_tr,
    input  logic [SA_W-1:0]   cmd_sa,
    input  logic              cmd_bcast,
    input  logic              idx_zero,
    input  logic              glb_idx_irq_en,
    input  logic              glb_acc_irq_en,
    output logic              busy_resp,
    output logic              irq_idx_zero,
    output logic              irq_access,
    output logic              irq_line,
    output logic              log_req
);
    st_t               st_d, st_q;
    logic              hit;
    logic              req_idx, req_acc;
    logic [WORD_W-1:0] host_word;
    logic [WORD_W-1:0] word_q;

    assign word_q = st_q.word;

    tsa_cmd_qual #(.SA_W(SA_W), .SA_LO(SA_LO), .SA_HI(SA_HI)) u_qual (
        .msg_done (msg_done),
        .exec_en  (exec_en),
        .cmd_tr   (cmd_tr),
        .cmd_sa   (cmd_sa),
        .hit      (hit)
    );

    tsa_host_merge u_merge (
        .cur     (st_q.word),
        .wdata   (host_wdata),
        .wr      (host_wr),
        .exec_en (exec_en),
        .merged  (host_word)
    );

    tsa_irq_req u_irq (
        .hit          (hit),
        .idx_zero     (idx_zero),
        .en_idx_local (st_q.word[B_IDX_IRQ]),
        .en_acc_local (st_q.word[B_ACC_IRQ]),
        .en_idx_glb   (glb_idx_irq_en),
        .en_acc_glb   (glb_acc_irq_en),
        .req_idx      (req_idx),
        .req_acc      (req_acc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.word    = host_word;
        st_d.irq_idx = 1'b0;
        st_d.irq_acc = 1'b0;
        if (host_rd) begin
            st_d.word[B_ACCESSED] = 1'b0;
        end
        if (soft_rst) begin
            st_d.word = st_d.word & ~M_SOFT;
        end else if (hit) begin
            st_d.word[B_ACCESSED] = 1'b1;
            if (cmd_bcast) begin
                st_d.word[B_BCAST] = 1'b1;
            end
            if (!st_q.word[B_BUSY]) begin
                st_d.word[B_BUFSEL] = ~st_q.word[B_BUFSEL];
            end
            st_d.irq_idx = req_idx;
            st_d.irq_acc = req_acc;
        end
        st_d.word[B_SPARE] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata   = word_q;
    assign busy_resp    = word_q[B_BUSY];
    assign irq_idx_zero = st_q.irq_idx;
    assign irq_access   = st_q.irq_acc;
    assign irq_line     = st_q.irq_idx | st_q.irq_acc;
    assign log_req      = st_q.irq_idx | st_q.irq_acc;
endmodule

// File: rtl/tx_sa_ctrl_word_chk.sv
`timescale 1ns/1ps
module tx_sa_ctrl_word_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exec_en,
    input logic        soft_rst,
    input logic        host_rd,
    input logic        msg_done,
    input logic        cmd_tr,
    input logic        glb_idx_irq_en,
    input logic [15:0] word,
    input logic [15:0] host_rdata,
    input logic        busy_resp,
    input logic        irq_idx_zero,
    input logic        irq_access
);
    a_r2_spare_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[13] == 1'b0);

    a_r3_idle_bits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> ($stable(word[7:4]) && $stable(word[2:0])));

    a_r4_status_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_done && !soft_rst && !host_rd) |=> $stable(word[11:8]));

    a_r7_busy_holds_bufsel: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_resp && !soft_rst) |=> $stable(word[10]));

    a_r9_soft_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (word[11:9] == 3'b000));

    a_r10_access_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_access |-> $past(msg_done && cmd_tr && exec_en));

    a_r11_idx_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_zero |-> $past(glb_idx_irq_en && word[15]));
endmodule

bind tx_sa_ctrl_word tx_sa_ctrl_word_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exec_en        (exec_en),
    .soft_rst       (soft_rst),
    .host_rd        (host_rd),
    .msg_done       (msg_done),
    .cmd_tr         (cmd_tr),
    .glb_idx_irq_en (glb_idx_irq_en),
    .word           (word_q),
    .host_rdata     (host_rdata),
    .busy_resp      (busy_resp),
    .irq_idx_zero   (irq_idx_zero),
    .irq_access     (irq_access)
);

// File: tb/tb_tx_sa_ctrl_word.sv
`timescale 1ns/1ps
module tb_tx_sa_ctrl_word;
    logic        clk = 1'b0;
    logic        rst_n, soft_rst, exec_en, host_wr, host_rd;
    logic [15:0] host_wdata, host_rdata;
    logic        msg_done, cmd_tr, cmd_bcast, idx_zero;
    logic [4:0]  cmd_sa;
    logic        glb_idx_irq_en, glb_acc_irq_en;
    logic        busy_resp, irq_idx_zero, irq_access, irq_line, log_req;
    int          nchk = 0;
    int          nfail = 0;

    always #4 clk = ~clk;

    tx_sa_ctrl_word dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .exec_en(exec_en),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .msg_done(msg_done), .cmd_tr(cmd_tr),
        .cmd_sa(cmd_sa), .cmd_bcast(cmd_bcast), .idx_zero(idx_zero),
        .glb_idx_irq_en(glb_idx_irq_en), .glb_acc_irq_en(glb_acc_irq_en),
        .busy_resp(busy_resp), .irq_idx_zero(irq_idx_zero),
        .irq_access(irq_access), .irq_line(irq_line), .log_req(log_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic [3:0] exp);
        chk(tag, {12'h0, irq_idx_zero, irq_access, irq_line, log_req}, {12'h0, exp});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] d);
        host_wr = 1'b1; host_wdata = d;
        step();
        host_wr = 1'b0;
    endtask

    task automatic done(input logic tr, input logic [4:0] sa, input logic bc, input logic iz);
        msg_done = 1'b1; cmd_tr = tr; cmd_sa = sa; cmd_bcast = bc; idx_zero = iz;
        step();
        msg_done = 1'b0; cmd_tr = 1'b0; cmd_sa = '0; cmd_bcast = 1'b0; idx_zero = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 word after master reset", host_rdata, 16'h0000);
        chk("R1 busy after reset", {15'h0, busy_resp}, 16'h0);
        chk_irq("R1 irqs after reset", 4'b0000);
    endtask

    task automatic t_host_access();
        exec_en = 1'b0;
        wr(16'hFFFF);
        chk("R3 R4 idle write all ones", host_rdata, 16'hD0FF);
        chk("R2 spare bit reads zero", {15'h0, host_rdata[13]}, 16'h0);
        chk("R7 busy_resp follows bit12", {15'h0, busy_resp}, 16'h1);
        exec_en = 1'b1;
        wr(16'h0000);
        chk("R2 R3 running write zeros", host_rdata, 16'h00F7);
        wr(16'hFFFF);
        chk("R2 running write ones", host_rdata, 16'hD0FF);
        wr(16'h0F00);
        chk("R4 status bits not host writable", host_rdata, 16'h00F7);
        exec_en = 1'b0;
        wr(16'h0000);
        chk("R3 idle clear", host_rdata, 16'h0000);
    endtask

    task automatic t_qualify();
        glb_acc_irq_en = 1'b1; glb_idx_irq_en = 1'b1;
        exec_en = 1'b1;
        wr(16'hC000);
        done(1'b1, 5'd0, 1'b0, 1'b1);
        chk("R5 subaddress 0 ignored", host_rdata, 16'hC000);
        chk_irq("R5 no irq for sa 0", 4'b0000);
        done(1'b1, 5'd31, 1'b0, 1'b1);
        chk("R5 subaddress 31 ignored", host_rdata, 16'hC000);
        done(1'b0, 5'd5, 1'b0, 1'b1);
        chk("R5 receive command ignored", host_rdata, 16'hC000);
        chk_irq("R5 no irq for receive", 4'b0000);
        exec_en = 1'b0;
        done(1'b1, 5'd5, 1'b0, 1'b1);
        chk("R5 stopped terminal ignored", host_rdata, 16'hC000);
        exec_en = 1'b1;
        wr(16'h0000);
        done(1'b1, 5'd1, 1'b0, 1'b0);
        chk("R6 R7 first valid completion", host_rdata, 16'h0C00);
        chk_irq("R10 no irq with local enables off", 4'b0000);
    endtask

    task automatic t_read_clear();
        host_rd = 1'b1;
        #1;
        chk("R8 read returns word", host_rdata, 16'h0C00);
        step();
        host_rd = 1'b0;
        chk("R8 read clears accessed", host_rdata, 16'h0400);
        host_rd = 1'b1;
        done(1'b1, 5'd30, 1'b1, 1'b0);
        host_rd = 1'b0;
        chk("R8 R6 set beats read clear", host_rdata, 16'h0A00);
    endtask

    task automatic t_busy();
        wr(16'h1000);
        chk("R2 busy bit written while running", host_rdata, 16'h1A00);
        chk("R7 busy_resp high", {15'h0, busy_resp}, 16'h1);
        done(1'b1, 5'd7, 1'b0, 1'b0);
        chk("R7 busy freezes buffer select", host_rdata, 16'h1A00);
        wr(16'h0000);
        done(1'b1, 5'd7, 1'b0, 1'b0);
        chk("R7 toggle resumes when not busy", host_rdata, 16'h0E00);
    endtask

    task automatic t_soft();
        wr(16'hC008);
        chk("R2 enables written", host_rdata, 16'hCE08);
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        chk("R9 soft reset clears status only", host_rdata, 16'hC008);
        soft_rst = 1'b1;
        done(1'b1, 5'd3, 1'b1, 1'b1);
        soft_rst = 1'b0;
        chk("R9 soft reset beats completion", host_rdata, 16'hC008);
        chk_irq("R9 no irq under soft reset", 4'b0000);
    endtask

    task automatic t_irq();
        done(1'b1, 5'd3, 1'b0, 1'b0);
        chk_irq("R10 R12 access irq pulse", 4'b0111);
        step();
        chk_irq("R10 access irq one cycle", 4'b0000);
        done(1'b1, 5'd3, 1'b0, 1'b1);
        chk_irq("R11 R12 both irqs", 4'b1111);
        glb_idx_irq_en = 1'b0;
        done(1'b1, 5'd3, 1'b0, 1'b1);
        chk_irq("R11 global index enable off", 4'b0111);
        glb_idx_irq_en = 1'b1;
        wr(16'h8000);
        done(1'b1, 5'd3, 1'b0, 1'b1);
        chk_irq("R11 index irq alone", 4'b1011);
        done(1'b1, 5'd3, 1'b0, 1'b0);
        chk_irq("R11 no index irq without idx_zero", 4'b0000);
        glb_acc_irq_en = 1'b0;
        wr(16'h4000);
        done(1'b1, 5'd3, 1'b0, 1'b0);
        chk_irq("R10 global access enable off", 4'b0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; exec_en = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        host_wdata = '0; msg_done = 1'b0; cmd_tr = 1'b0; cmd_sa = '0; cmd_bcast = 1'b0;
        idx_zero = 1'b0; glb_idx_irq_en = 1'b0; glb_acc_irq_en = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_host_access();
        t_qualify();
        t_read_clear();
        t_busy();
        t_soft();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule